// File: doc/BRIEF.md
# E1 Multiframe Overhead Bit Buffers

This block gathers and supplies the spare overhead bits carried in timeslot zero of an E1 stream, one bit per eligible frame across a 16-frame CRC4 multiframe. On the receive side, eight shift registers each collect eight successive occurrences of one overhead bit. At the end of the multiframe, each register is copied into a stable host-readable buffer, and a sticky status flag is raised. The host then has one multiframe period to read the buffer before the next copy replaces it.

On the transmit side, the host writes eight staging bytes. At the transmit multiframe boundary, all eight are loaded at once into shift registers. Each shift register then gives up one bit, most significant first, in every frame that carries its overhead bit. An eight-bit mask chooses, per register, whether that bit replaces the upstream stream bit or lets the upstream bit pass. A staging byte that is not rewritten is sent again in every multiframe.

Frame number within the multiframe, bit position within timeslot zero, and the timeslot-zero marker are all supplied from outside. Multiframe alignment is not found here.

Top module: `e1_mf_overhead`

## Requirements
- R1: Frames 0, 2, …, 14 are align frames, and frames 1, 3, …, 15 are non-align frames. Bit position 0 is the first bit of timeslot zero.
  - In an align frame, position 0 feeds register 7 (Si in align frames).
  - In a non-align frame, position 0 feeds register 6 (Si in non-align frames), position 2 feeds register 5 (remote alarm), and positions 3, 4, 5, 6 and 7 feed registers 4, 3, 2, 1 and 0 (Sa4 through Sa8).
- R2: The first occurrence of a bit in a multiframe ends up in bit 7 of its register. Register k is presented on `rx_sa_data[8k+7:8k]`.
- R3: `rx_sa_data` changes only in the cycle after the position-7 bit of frame 15 is accepted. It then holds all eight registers, including that last bit. It is stable at all other times.
- R4: A bit has no effect when `rx_bit_en` is low, when `rx_ts0` is low, or when it sits at a position that feeds no register (position 1 of non-align frames, positions 1 to 7 of align frames).
- R5: `rx_mf_flag` rises in the cycle after the receive multiframe end. It stays high until a cycle with `rx_flag_clr` high and no multiframe end. If set and clear occur in the same cycle, set wins.
- R6: A cycle with `tx_wr_en` high writes `tx_wr_data` into staging register `tx_wr_sel`, numbered as in R1.
- R7: All eight staging registers are loaded into the transmit shifters after the position-7 bit of transmit frame 15. A write made after that load is first sent in the multiframe that follows the next load. `tx_mf_flag` behaves as in R5, using its own boundary and `tx_flag_clr`.
- R8: In each slot of R1 on the transmit side, the register's bits are sent in order from bit 7 to bit 0 over the eight frames of that slot type.
- R9: `tx_bit_out` equals the register bit in a slot whose `tx_mask` bit (index k as in R1) is 1. It equals `tx_bit_in` in every other slot and position. `tx_bit_out` is combinational from the current inputs.
- R10: Without new writes, the same staging contents are sent again in every multiframe.
- R11: After a synchronous active-low reset, all shift, buffer and staging registers are zero and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit_en | input | 1 | Receive bit strobe |
| rx_ts0 | input | 1 | Receive bit lies in timeslot zero |
| rx_frame | input | 4 | Receive frame number in the multiframe |
| rx_pos | input | 3 | Receive bit position in timeslot zero |
| rx_bit | input | 1 | Receive data bit |
| rx_flag_clr | input | 1 | Write-one-to-clear for the receive flag |
| rx_mf_flag | output | 1 | Receive buffer updated (sticky) |
| rx_sa_data | output | 64 | Eight receive buffers, register k at [8k+7:8k] |
| tx_bit_en | input | 1 | Transmit bit strobe |
| tx_ts0 | input | 1 | Transmit bit lies in timeslot zero |
| tx_frame | input | 4 | Transmit frame number in the multiframe |
| tx_pos | input | 3 | Transmit bit position in timeslot zero |
| tx_bit_in | input | 1 | Upstream transmit bit |
| tx_mask | input | 8 | Per-register insert enable |
| tx_wr_en | input | 1 | Staging register write strobe |
| tx_wr_sel | input | 3 | Staging register index |
| tx_wr_data | input | 8 | Staging register write data |
| tx_flag_clr | input | 1 | Write-one-to-clear for the transmit flag |
| tx_mf_flag | output | 1 | Transmit registers sampled (sticky) |
| tx_bit_out | output | 1 | Transmit bit after insertion |

## Verification
Two events can fall in the same cycle: the host clearing the receive flag, and the hardware setting it at the multiframe end. The bench provokes this by raising `rx_flag_clr` together with the position-7 bit of frame 15. It then expects the flag to stay high and the buffer to show the new multiframe in full. In another run, the last frame is withheld, and the bench expects both the buffer and the cleared flag to stay unchanged.

// File: rtl/oh_mf_pkg.sv
// Package: shared constants and the slot-to-register mapping for the
// multiframe overhead buffers. Assumes an E1 timeslot zero of eight bits
// and alternating align / non-align frames, frame 0 being an align frame.
package oh_mf_pkg;
    localparam int NREG          = 8;                  // registers per direction
    localparam int BITS_PER_REG  = 8;                  // occurrences per multiframe
    localparam int SLOT_BITS     = 8;                  // bits in timeslot zero
    localparam int FRAMES        = 2 * BITS_PER_REG;   // frames per multiframe
    localparam int FRAME_W       = $clog2(FRAMES);
    localparam int POS_W         = $clog2(SLOT_BITS);
    localparam int IDX_W         = $clog2(NREG);
    localparam int DATA_W        = NREG * BITS_PER_REG;
    localparam int IDX_SI_ALIGN  = 7;
    localparam int IDX_SI_NALIGN = 6;
    localparam int IDX_ALARM     = 5;
    localparam int IDX_SA_FIRST  = 4;                  // Sa4; Sa8 sits at 0
    localparam int POS_ALARM     = 2;
    localparam int POS_SA_FIRST  = 3;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } slot_map_t;

    // Map (frame type, bit position) to the register it feeds, if any.
    function automatic slot_map_t map_slot(input logic align, input logic [POS_W-1:0] pos);
        slot_map_t m;
        m.hit = 1'b0;
        m.idx = '0;
        if (align) begin
            if (pos == '0) begin
                m.hit = 1'b1;
                m.idx = IDX_W'(IDX_SI_ALIGN);
            end
        end else if (pos == '0) begin
            m.hit = 1'b1;
            m.idx = IDX_W'(IDX_SI_NALIGN);
        end else if (pos == POS_W'(POS_ALARM)) begin
            m.hit = 1'b1;
            m.idx = IDX_W'(IDX_ALARM);
        end else if (pos >= POS_W'(POS_SA_FIRST)) begin
            m.hit = 1'b1;
            m.idx = IDX_W'(IDX_SA_FIRST + POS_SA_FIRST) - IDX_W'(pos);
        end
        return m;
    endfunction
endpackage

// File: rtl/oh_slot_decode.sv
// Slot decoder: turns frame number, bit position and strobes into a one-hot
// register select and a multiframe-end pulse. Assumes the frame number is
// already aligned to the CRC4 multiframe by the caller.
module oh_slot_decode
    import oh_mf_pkg::*;
(
    input  logic               bit_en,
    input  logic               ts0,
    input  logic [FRAME_W-1:0] frame,
    input  logic [POS_W-1:0]   pos,
    output logic [NREG-1:0]    sel,
    output logic               mf_end
);
    slot_map_t m;

    // Look up which register this bit position belongs to.
    assign m = map_slot(~frame[0], pos);

    // Raise at most one select, only for accepted timeslot-zero bits.
    always_comb begin
        sel = '0;
        if (bit_en && ts0 && m.hit) begin
            sel[m.idx] = 1'b1;
        end
    end

    // The last bit of frame 15's timeslot zero closes the multiframe.
    assign mf_end = bit_en && ts0 && (frame == FRAME_W'(FRAMES - 1))
                    && (pos == POS_W'(SLOT_BITS - 1));
endmodule

// File: rtl/oh_sticky_flag.sv
// Sticky status flag: set by a hardware event, cleared by a host
// write-one-to-clear. A set in the same cycle as a clear wins.
module oh_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag until the host clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    p_flag_set_r5_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
    p_flag_clear_r5_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);
endmodule

// File: rtl/oh_rx_collect.sv
// Receive collector: one shift register per overhead bit gathers a bit in
// each selected frame (first bit ends at the MSB). At the multiframe end the
// updated shift contents are copied to stable host buffers.
module oh_rx_collect
    import oh_mf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   sel,
    input  logic              bit_in,
    input  logic              mf_end,
    output logic [DATA_W-1:0] data
);
    logic [BITS_PER_REG-1:0] shift_q [NREG];
    logic [BITS_PER_REG-1:0] shift_d [NREG];
    logic [BITS_PER_REG-1:0] hold_q  [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        // Next shift value: append the new bit at the LSB when selected.
        always_comb begin
            shift_d[k] = sel[k] ? {shift_q[k][BITS_PER_REG-2:0], bit_in} : shift_q[k];
        end

        // Advance the shifter; copy its updated value at the multiframe end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shift_q[k] <= '0;
                hold_q[k]  <= '0;
            end else begin
                shift_q[k] <= shift_d[k];
                if (mf_end) hold_q[k] <= shift_d[k];
            end
        end

        assign data[k*BITS_PER_REG +: BITS_PER_REG] = hold_q[k];

        p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !mf_end |=> $stable(hold_q[k]));
        p_shift_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !sel[k] |=> $stable(shift_q[k]));
    end
endmodule

// File: rtl/oh_tx_insert.sv
// Transmit inserter: host-written staging bytes are loaded into shifters at
// the multiframe end; each shifter gives its MSB in its slot and shifts. The
// mask picks, per register, insertion or pass-through of the upstream bit.
module oh_tx_insert
    import oh_mf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_sel,
    input  logic [BITS_PER_REG-1:0] wr_data,
    input  logic [NREG-1:0]  sel,
    input  logic             mf_end,
    input  logic [NREG-1:0]  mask,
    input  logic             bit_in,
    output logic             bit_out
);
    logic [BITS_PER_REG-1:0] stage_q [NREG];
    logic [BITS_PER_REG-1:0] shift_q [NREG];
    logic [NREG-1:0]         msb_v;

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        // Staging register written by the host.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   stage_q[k] <= '0;
            else if (wr_en && (wr_sel == IDX_W'(k)))      stage_q[k] <= wr_data;
        end

        // Load from staging at the multiframe end, otherwise shift when used.
        always_ff @(posedge clk) begin
            if (!rst_n)      shift_q[k] <= '0;
            else if (mf_end) shift_q[k] <= stage_q[k];
            else if (sel[k]) shift_q[k] <= {shift_q[k][BITS_PER_REG-2:0], 1'b0};
        end

        assign msb_v[k] = shift_q[k][BITS_PER_REG-1];

        p_sample_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
            mf_end |=> (shift_q[k] == $past(stage_q[k])));
        p_shift_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!mf_end && !sel[k]) |=> $stable(shift_q[k]));
    end

    // Replace the stream bit only in an enabled register's slot.
    assign bit_out = (|(sel & mask)) ? (|(sel & msb_v)) : bit_in;
endmodule

// File: rtl/e1_mf_overhead.sv
// Top: receive and transmit overhead bit buffers over a CRC4 multiframe.
// Assumes frame number and timeslot-zero position come from an external
// multiframe aligner on each side; both sides run on one clock with strobes.
module e1_mf_overhead
    import oh_mf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_bit_en,
    input  logic               rx_ts0,
    input  logic [FRAME_W-1:0] rx_frame,
    input  logic [POS_W-1:0]   rx_pos,
    input  logic               rx_bit,
    input  logic               rx_flag_clr,
    output logic               rx_mf_flag,
    output logic [DATA_W-1:0]  rx_sa_data,
    input  logic               tx_bit_en,
    input  logic               tx_ts0,
    input  logic [FRAME_W-1:0] tx_frame,
    input  logic [POS_W-1:0]   tx_pos,
    input  logic               tx_bit_in,
    input  logic [NREG-1:0]    tx_mask,
    input  logic               tx_wr_en,
    input  logic [IDX_W-1:0]   tx_wr_sel,
    input  logic [BITS_PER_REG-1:0] tx_wr_data,
    input  logic               tx_flag_clr,
    output logic               tx_mf_flag,
    output logic               tx_bit_out
);
    logic [NREG-1:0] rx_sel, tx_sel;
    logic            rx_end, tx_end;

    oh_slot_decode u_rx_dec (
        .bit_en(rx_bit_en), .ts0(rx_ts0), .frame(rx_frame), .pos(rx_pos),
        .sel(rx_sel), .mf_end(rx_end)
    );

    oh_rx_collect u_rx (
        .clk(clk), .rst_n(rst_n), .sel(rx_sel), .bit_in(rx_bit),
        .mf_end(rx_end), .data(rx_sa_data)
    );

    oh_sticky_flag u_rx_flag (
        .clk(clk), .rst_n(rst_n), .set(rx_end), .clr(rx_flag_clr), .q(rx_mf_flag)
    );

    oh_slot_decode u_tx_dec (
        .bit_en(tx_bit_en), .ts0(tx_ts0), .frame(tx_frame), .pos(tx_pos),
        .sel(tx_sel), .mf_end(tx_end)
    );

    oh_tx_insert u_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(tx_wr_en), .wr_sel(tx_wr_sel),
        .wr_data(tx_wr_data), .sel(tx_sel), .mf_end(tx_end), .mask(tx_mask),
        .bit_in(tx_bit_in), .bit_out(tx_bit_out)
    );

    oh_sticky_flag u_tx_flag (
        .clk(clk), .rst_n(rst_n), .set(tx_end), .clr(tx_flag_clr), .q(tx_mf_flag)
    );
endmodule

// File: tb/e1_mf_overhead_tb.sv
module e1_mf_overhead_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_bit_en = 0, rx_ts0 = 0, rx_bit = 0, rx_flag_clr = 0;
    logic [3:0]  rx_frame = 0;
    logic [2:0]  rx_pos = 0;
    logic        rx_mf_flag;
    logic [63:0] rx_sa_data;
    logic        tx_bit_en = 0, tx_ts0 = 0, tx_bit_in = 0, tx_wr_en = 0, tx_flag_clr = 0;
    logic [3:0]  tx_frame = 0;
    logic [2:0]  tx_pos = 0;
    logic [7:0]  tx_mask = 0;
    logic [2:0]  tx_wr_sel = 0;
    logic [7:0]  tx_wr_data = 0;
    logic        tx_mf_flag, tx_bit_out;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [63:0] RX_VEC [4] = '{
        64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_A5A5_5A5A,
        64'h8000_0000_0000_0001, 64'hDEAD_BEEF_C0DE_F00D };
    localparam logic [63:0] PAT_X = 64'h1357_9BDF_2468_ACE0;
    localparam logic [63:0] D1    = 64'h96C3_3C69_0FF0_E71B;
    localparam logic [63:0] D2    = 64'h5AA5_1248_FEDC_7700;

    always #10 clk = ~clk;   // 50 MHz

    e1_mf_overhead u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_bit_en(rx_bit_en), .rx_ts0(rx_ts0), .rx_frame(rx_frame), .rx_pos(rx_pos),
        .rx_bit(rx_bit), .rx_flag_clr(rx_flag_clr), .rx_mf_flag(rx_mf_flag),
        .rx_sa_data(rx_sa_data),
        .tx_bit_en(tx_bit_en), .tx_ts0(tx_ts0), .tx_frame(tx_frame), .tx_pos(tx_pos),
        .tx_bit_in(tx_bit_in), .tx_mask(tx_mask), .tx_wr_en(tx_wr_en),
        .tx_wr_sel(tx_wr_sel), .tx_wr_data(tx_wr_data), .tx_flag_clr(tx_flag_clr),
        .tx_mf_flag(tx_mf_flag), .tx_bit_out(tx_bit_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Register fed by a frame/position pair, per R1; -1 when none.
    function automatic int slot_of(input int f, input int p);
        if (f % 2 == 0) return (p == 0) ? 7 : -1;
        if (p == 0) return 6;
        if (p == 1) return -1;
        if (p == 2) return 5;
        return 7 - p;
    endfunction

    task automatic rx_step(input logic en, input logic t, input int f, input int p,
                           input logic b, input logic clr);
        @(negedge clk);
        rx_bit_en = en; rx_ts0 = t; rx_frame = 4'(f); rx_pos = 3'(p);
        rx_bit = b; rx_flag_clr = clr;
    endtask

    task automatic rx_idle;
        @(negedge clk);
        rx_bit_en = 0; rx_ts0 = 0; rx_flag_clr = 0;
    endtask

    task automatic rx_frames(input logic [63:0] pat, input int lo, input int hi,
                             input bit noise, input bit clr_last);
        for (int f = lo; f <= hi; f++) begin
            for (int p = 0; p < 8; p++) begin
                int k;
                logic b;
                k = slot_of(f, p);
                b = (k >= 0) ? pat[8*k + 7 - f/2] : 1'((f + p) % 2);
                if (noise) begin
                    rx_step(1'b0, 1'b1, f, p, ~b, 1'b0);   // strobe low (R4)
                    rx_step(1'b1, 1'b0, f, p, ~b, 1'b0);   // not timeslot zero (R4)
                end
                rx_step(1'b1, 1'b1, f, p, b, clr_last && f == 15 && p == 7);
            end
        end
    endtask

    task automatic tx_write(input int k, input logic [7:0] d);
        @(negedge clk);
        tx_wr_en = 1; tx_wr_sel = 3'(k); tx_wr_data = d;
        @(negedge clk);
        tx_wr_en = 0;
    endtask

    task automatic tx_load_all(input logic [63:0] d);
        for (int k = 0; k < 8; k++) tx_write(k, d[8*k +: 8]);
    endtask

    task automatic tx_mf(input logic [63:0] d, input bit chk, input string tag);
        for (int f = 0; f < 16; f++) begin
            for (int p = 0; p < 8; p++) begin
                int k;
                logic e;
                @(negedge clk);
                tx_bit_en = 1; tx_ts0 = 1; tx_frame = 4'(f); tx_pos = 3'(p);
                tx_bit_in = 1'((f + p + 1) % 2);
                #2;
                k = slot_of(f, p);
                e = (k >= 0 && tx_mask[k]) ? d[8*k + 7 - f/2] : tx_bit_in;
                if (chk) check(tag, 64'(tx_bit_out), 64'(e));
            end
        end
        @(negedge clk);
        tx_bit_en = 0; tx_ts0 = 0;
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        check("R11 rx data", rx_sa_data, 64'h0);
        check("R11 rx flag", 64'(rx_mf_flag), 64'h0);
        check("R11 tx flag", 64'(tx_mf_flag), 64'h0);
        tx_mask = 8'hFF;
        tx_bit_en = 1; tx_ts0 = 1; tx_frame = 0; tx_pos = 0; tx_bit_in = 1;
        #2;
        check("R11 tx shifter zero", 64'(tx_bit_out), 64'h0);
        tx_mask = 8'h00;
        #2;
        check("R9 pass-through", 64'(tx_bit_out), 64'h1);
        @(negedge clk);
        tx_bit_en = 0; tx_ts0 = 0;

        // Table walk: R1 R2 R4 R5 per vector
        for (int i = 0; i < 4; i++) begin
            rx_frames(RX_VEC[i], 0, 15, i >= 2, 1'b0);
            rx_idle;
            check("R1 R2 R4 rx data", rx_sa_data, RX_VEC[i]);
            check("R5 rx flag set", 64'(rx_mf_flag), 64'h1);
            rx_step(1'b0, 1'b0, 0, 0, 1'b0, 1'b1);
            rx_idle;
            check("R5 rx flag clear", 64'(rx_mf_flag), 64'h0);
        end

        // R3: no update before the multiframe end
        rx_frames(PAT_X, 0, 14, 1'b0, 1'b0);
        rx_idle;
        check("R3 buffer stable", rx_sa_data, RX_VEC[3]);
        check("R3 flag quiet", 64'(rx_mf_flag), 64'h0);
        // R5: clear in the same cycle as set; set wins
        rx_frames(PAT_X, 15, 15, 1'b0, 1'b1);
        rx_idle;
        check("R3 buffer updated", rx_sa_data, PAT_X);
        check("R5 set beats clear", 64'(rx_mf_flag), 64'h1);

        // Transmit: R6 R7 R8 R9 R10
        tx_load_all(D1);
        tx_mask = 8'hFF;
        tx_mf(D1, 1'b0, "");
        @(negedge clk);
        check("R7 tx flag set", 64'(tx_mf_flag), 64'h1);
        tx_flag_clr = 1;
        @(negedge clk);
        tx_flag_clr = 0;
        @(negedge clk);
        check("R7 tx flag clear", 64'(tx_mf_flag), 64'h0);
        tx_mf(D1, 1'b1, "R6 R8 full insert");
        tx_mask = 8'hA5;
        tx_mf(D1, 1'b1, "R9 R10 masked repeat");
        tx_load_all(D2);
        tx_mask = 8'hFF;
        tx_mf(D1, 1'b1, "R7 write waits for load");
        tx_mf(D2, 1'b1, "R7 R8 new data");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule